// File: doc/BRIEF.md
# Guarded Indirect Scratch-RAM Access Port

This block gives a host an indirect window into a small single-port data RAM that a protocol engine owns. The host writes a command word holding an operation code and a word address. For writes it also writes a data word. The block then waits for a cycle in which the engine leaves the RAM alone, performs the access and sets a done flag. Software polls that flag and only then reads the data word, which holds either the word that was read, the read-back of the word just written, or zero for a refused write.

The engine's own traffic enters through a request port and always takes the RAM in the cycle it asks for it, so a host access can wait for as long as the engine stays busy. Host writes are guarded by the controller state. In the default configuration state any word may be written. In any other state only one reserved word (address 0x70, never touched by the engine) accepts host writes. A refused write leaves the RAM untouched and returns zero.

Top module: `scratch_access_port`

## Requirements
- R1: After reset, `cmd_rdata`, `data_rdata` and `eng_rdata` are all zero and no access is pending.
- R2: The command word carries the operation in bits [15:12] (0x2 = read, 0x3 = write) and the word address in bits [7:1]. Reading it back returns the stored bits [15:1] with the done flag in bit 0. For example, 0x30E0 is a write to address 0x70.
- R3: A read command ends with done = 1 and `data_rdata` equal to the RAM word at the given address.
- R4: An accepted write stores the data word. In the first free cycle after it, which is the next cycle when the engine is idle, the block reads the same word back into the data register. With the engine idle, done is visible 4 clock edges after the command edge; for a read it is visible after 3.
- R5: While `cfg_default` is 1, a write to any address is accepted.
- R6: While `cfg_default` is 0, only address 0x70 accepts a write. A write to any other address leaves the RAM unchanged, loads 0x0000 into the data register and sets done.
- R7: An engine request always gets the RAM in that same cycle. A host access uses only cycles with no engine request and stays pending, with done = 0, for as long as the engine keeps requesting (tested with a 1000-cycle hold).
- R8: An accepted command clears done. A command written while an access is pending is ignored and the stored command is unchanged.
- R9: A command with an operation other than 0x2/0x3, or with any of bits [11:8] or bit 0 set, is not performed. Done is set at the next edge, the data register is unchanged and the RAM is not accessed.
- R10: The data register takes host writes only while no access is pending. A data write during a pending access is ignored, and a pending write stores the value it had when the command was accepted.
- R11: An engine read returns the addressed word on `eng_rdata` one edge after the request cycle, and engine writes are visible to later host reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_default | input | 1 | 1 while the controller is in its default configuration state |
| cmd_we | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 16 | Command word written by the host |
| data_we | input | 1 | Host write strobe for the data word |
| data_wdata | input | DW | Data word written by the host |
| cmd_rdata | output | 16 | Stored command with done flag in bit 0 |
| data_rdata | output | DW | Data register: read result, read-back or zero |
| eng_req | input | 1 | Engine RAM request, always served this cycle |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | AW | Engine word address |
| eng_wdata | input | DW | Engine write data |
| eng_rdata | output | DW | RAM read data, valid one edge after an engine read |

## Verification
The main access path is driven from a vector table that mixes reads and writes in both controller states. It covers accepted writes to ordinary words, refused writes to those words, and writes to the reserved word 0x70. A refused write is told apart from an accepted one both by the zero it returns and by a later read of the same address showing the old contents. Directed sequences hold the engine request for 1000 cycles to separate "waiting" from "lost", and they issue a second command and a data write during that wait. They also send malformed commands and measure the idle-engine latency edge by edge, so that the next-cycle read-back can be distinguished from a slower path.

// File: rtl/sap_pkg.sv
// Package: shared constants and types for the scratch-RAM access port.
// Assumes a 16-bit command word with the operation in the top nibble.
package sap_pkg;
    localparam int CMD_W  = 16;
    localparam int OP_W   = 4;
    localparam int OP_LSB = CMD_W - OP_W;

    localparam logic [OP_W-1:0] OP_READ  = 4'h2;
    localparam logic [OP_W-1:0] OP_WRITE = 4'h3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_RBACK = 2'd2,
        ST_CAPT  = 2'd3
    } sap_state_t;
endpackage

// File: rtl/sap_cmd_decode.sv
// Module: sap_cmd_decode
// Splits a command word into operation and address, flags malformed
// words and decides whether a write is permitted in the current state.
// Assumes AW <= OP_LSB - 1 so the address field fits below the opcode.
module sap_cmd_decode
    import sap_pkg::*;
#(
    parameter int AW = 7,
    parameter logic [AW-1:0] FREE_ADDR = 7'h70
) (
    input  logic [CMD_W-1:0] cmd,
    input  logic             cfg_default,
    output logic [AW-1:0]    addr,
    output logic             is_rd,
    output logic             is_wr,
    output logic             valid,
    output logic             wr_ok
);
    localparam int SPARE_LSB = AW + 1;
    localparam int SPARE_W   = OP_LSB - SPARE_LSB;

    logic [OP_W-1:0] op;
    logic            spare_clear;

    // Field extraction.
    always_comb begin
        op   = cmd[CMD_W-1:OP_LSB];
        addr = cmd[AW:1];
    end

    // Bits between the address field and the opcode must be zero.
    generate
        if (SPARE_W > 0) begin : g_spare
            assign spare_clear = (cmd[OP_LSB-1:SPARE_LSB] == '0);
        end else begin : g_nospare
            assign spare_clear = 1'b1;
        end
    endgenerate

    // Classification and write permission.
    always_comb begin
        is_rd = (op == OP_READ);
        is_wr = (op == OP_WRITE);
        valid = (is_rd || is_wr) && spare_clear && !cmd[0];
        wr_ok = is_wr && (cfg_default || (addr == FREE_ADDR));
    end
endmodule

// File: rtl/sap_arbiter.sv
// Module: sap_arbiter
// Fixed-priority mux onto the single RAM port: the engine always wins,
// the host is granted only in cycles without an engine request.
// Assumes the engine never needs a grant back (it is always served).
module sap_arbiter #(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          eng_req,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [DW-1:0] eng_wdata,
    input  logic          host_req,
    input  logic          host_use,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_gnt,
    output logic          ram_en,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata
);
    // Grant and port steering.
    always_comb begin
        host_gnt = host_req && !eng_req;
        if (eng_req) begin
            ram_en    = 1'b1;
            ram_we    = eng_we;
            ram_addr  = eng_addr;
            ram_wdata = eng_wdata;
        end else begin
            ram_en    = host_gnt && host_use;
            ram_we    = host_gnt && host_use && host_we;
            ram_addr  = host_addr;
            ram_wdata = host_wdata;
        end
    end
endmodule

// File: rtl/sap_ram.sv
// Module: sap_ram
// Single-port synchronous RAM with a registered read output.
// Assumes contents are not reset; only the output register is.
module sap_ram #(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Storage write.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en && !we) begin
            q <= mem[addr];
        end
    end
endmodule

// File: rtl/sap_ctrl.sv
// Module: sap_ctrl
// Host-side sequencer: holds the command and data registers, waits for
// a free RAM cycle, issues the access, reads back after a write and
// sets done. Assumes the command presented to it has been decoded.
module sap_ctrl
    import sap_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_we,
    input  logic [CMD_W-1:1]   cmd_in,
    input  logic               new_valid,
    input  logic               data_we,
    input  logic [DW-1:0]      data_in,
    input  logic               cur_is_rd,
    input  logic               cur_wr_ok,
    input  logic [AW-1:0]      cur_addr,
    input  logic               host_gnt,
    input  logic [DW-1:0]      ram_q,
    output logic [CMD_W-1:1]   cmd_q,
    output logic               done_q,
    output logic [DW-1:0]      data_q,
    output logic               busy,
    output logic               host_req,
    output logic               host_use,
    output logic               host_we,
    output logic [AW-1:0]      host_addr,
    output logic [DW-1:0]      host_wdata
);
    sap_state_t state;

    // Sequencer, command, data and done registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cmd_q  <= '0;
            done_q <= 1'b0;
            data_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (data_we) begin
                        data_q <= data_in;
                    end
                    if (cmd_we) begin
                        cmd_q <= cmd_in;
                        if (new_valid) begin
                            done_q <= 1'b0;
                            state  <= ST_WAIT;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (host_gnt) begin
                        if (cur_is_rd) begin
                            state <= ST_CAPT;
                        end else if (cur_wr_ok) begin
                            state <= ST_RBACK;
                        end else begin
                            data_q <= '0;
                            done_q <= 1'b1;
                            state  <= ST_IDLE;
                        end
                    end
                end
                ST_RBACK: begin
                    if (host_gnt) begin
                        state <= ST_CAPT;
                    end
                end
                default: begin
                    data_q <= ram_q;
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
            endcase
        end
    end

    // RAM request signals for the arbiter.
    always_comb begin
        busy       = (state != ST_IDLE);
        host_req   = (state == ST_WAIT) || (state == ST_RBACK);
        host_use   = (state == ST_RBACK) ||
                     ((state == ST_WAIT) && (cur_is_rd || cur_wr_ok));
        host_we    = (state == ST_WAIT) && !cur_is_rd && cur_wr_ok;
        host_addr  = cur_addr;
        host_wdata = data_q;
    end
endmodule

// File: rtl/scratch_access_port.sv
// Module: scratch_access_port (top)
// Indirect host port into an engine-owned scratch RAM with state-based
// write protection. Assumes the engine request may be held for any
// length of time; the host access simply waits.
module scratch_access_port
    import sap_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter logic [AW-1:0] FREE_ADDR = 7'h70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_default,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic              data_we,
    input  logic [DW-1:0]     data_wdata,
    output logic [CMD_W-1:0]  cmd_rdata,
    output logic [DW-1:0]     data_rdata,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [AW-1:0]     eng_addr,
    input  logic [DW-1:0]     eng_wdata,
    output logic [DW-1:0]     eng_rdata
);
    logic [CMD_W-1:1] cmd_q;
    logic             done_q;
    logic             busy;
    logic             new_valid;
    logic [AW-1:0]    new_addr;
    logic             new_rd, new_wr, new_wr_ok;
    logic [AW-1:0]    cur_addr;
    logic             cur_rd, cur_wr, cur_valid, cur_wr_ok;
    logic             host_req, host_use, host_we, host_gnt;
    logic [AW-1:0]    host_addr;
    logic [DW-1:0]    host_wdata;
    logic             ram_en, ram_we;
    logic [AW-1:0]    ram_addr;
    logic [DW-1:0]    ram_wdata, ram_q;
    logic             unused_dec;

    // Decode of the incoming command word (acceptance check).
    sap_cmd_decode #(.AW(AW), .FREE_ADDR(FREE_ADDR)) u_dec_new (
        .cmd(cmd_wdata), .cfg_default(cfg_default), .addr(new_addr),
        .is_rd(new_rd), .is_wr(new_wr), .valid(new_valid), .wr_ok(new_wr_ok)
    );

    // Decode of the stored command (execution).
    sap_cmd_decode #(.AW(AW), .FREE_ADDR(FREE_ADDR)) u_dec_cur (
        .cmd({cmd_q, 1'b0}), .cfg_default(cfg_default), .addr(cur_addr),
        .is_rd(cur_rd), .is_wr(cur_wr), .valid(cur_valid), .wr_ok(cur_wr_ok)
    );

    sap_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we),
        .cmd_in(cmd_wdata[CMD_W-1:1]), .new_valid(new_valid),
        .data_we(data_we), .data_in(data_wdata),
        .cur_is_rd(cur_rd), .cur_wr_ok(cur_wr_ok), .cur_addr(cur_addr),
        .host_gnt(host_gnt), .ram_q(ram_q),
        .cmd_q(cmd_q), .done_q(done_q), .data_q(data_rdata), .busy(busy),
        .host_req(host_req), .host_use(host_use), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata)
    );

    sap_arbiter #(.AW(AW), .DW(DW)) u_arb (
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .host_req(host_req), .host_use(host_use),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_gnt(host_gnt), .ram_en(ram_en), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    sap_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .rst_n(rst_n), .en(ram_en), .we(ram_we),
        .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
    );

    // Read-back views; decode outputs not needed here are folded away.
    always_comb begin
        cmd_rdata  = {cmd_q, done_q};
        eng_rdata  = ram_q;
        unused_dec = ^{new_addr, new_rd, new_wr, new_wr_ok, cur_wr, cur_valid};
    end
endmodule

// File: rtl/sap_checker.sv
// Module: sap_checker
// Temporal checks on the access port, attached to every instance of
// the top through the bind statement below.
module sap_checker #(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter logic [AW-1:0] FREE_ADDR = 7'h70
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_default,
    input logic          cmd_we,
    input logic [15:0]   cmd_wdata,
    input logic          data_we,
    input logic [15:0]   cmd_rdata,
    input logic [DW-1:0] data_rdata,
    input logic          eng_req,
    input logic          eng_we,
    input logic [AW-1:0] eng_addr,
    input logic          busy,
    input logic          ram_en,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr
);
    logic new_ok;

    // Independent view of a well-formed command word.
    always_comb begin
        new_ok = ((cmd_wdata[15:12] == 4'h2) || (cmd_wdata[15:12] == 4'h3)) &&
                 (cmd_wdata[11:8] == 4'h0) && !cmd_wdata[0];
    end

    assert_engine_owns_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |-> (ram_en && ram_we == eng_we && ram_addr == eng_addr));

    assert_guarded_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && ram_we && !eng_req) |-> (cfg_default || ram_addr == FREE_ADDR));

    assert_pending_cmd_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> (cmd_rdata[15:1] == $past(cmd_rdata[15:1])));

    assert_accept_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && new_ok) |=> !cmd_rdata[0]);

    assert_malformed_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && !new_ok && !data_we) |=> (cmd_rdata[0] && $stable(data_rdata)));
endmodule

bind scratch_access_port sap_checker #(.AW(AW), .DW(DW), .FREE_ADDR(FREE_ADDR)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_default(cfg_default), .cmd_we(cmd_we),
    .cmd_wdata(cmd_wdata), .data_we(data_we), .cmd_rdata(cmd_rdata),
    .data_rdata(data_rdata), .eng_req(eng_req), .eng_we(eng_we),
    .eng_addr(eng_addr), .busy(busy), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr)
);

// File: tb/sim_scratch_access_port.sv
module sim_scratch_access_port;
    localparam int AW = 7;
    localparam int DW = 16;
    localparam int NV = 10;

    // Vector: {cfg[43], op[42:39], addr[38:32], wdata[31:16], expect[15:0]}
    localparam logic [43:0] VEC [NV] = '{
        {1'b1, 4'h3, 7'h05, 16'h1234, 16'h1234},
        {1'b1, 4'h2, 7'h05, 16'h0000, 16'h1234},
        {1'b0, 4'h3, 7'h05, 16'hBEEF, 16'h0000},
        {1'b0, 4'h2, 7'h05, 16'h0000, 16'h1234},
        {1'b0, 4'h3, 7'h70, 16'hCAFE, 16'hCAFE},
        {1'b0, 4'h2, 7'h70, 16'h0000, 16'hCAFE},
        {1'b1, 4'h3, 7'h7F, 16'h00FF, 16'h00FF},
        {1'b0, 4'h3, 7'h7F, 16'h5555, 16'h0000},
        {1'b1, 4'h2, 7'h7F, 16'h0000, 16'h00FF},
        {1'b1, 4'h3, 7'h70, 16'h0001, 16'h0001}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_default = 1'b1;
    logic          cmd_we = 1'b0;
    logic [15:0]   cmd_wdata = '0;
    logic          data_we = 1'b0;
    logic [DW-1:0] data_wdata = '0;
    logic [15:0]   cmd_rdata;
    logic [DW-1:0] data_rdata;
    logic          eng_req = 1'b0;
    logic          eng_we = 1'b0;
    logic [AW-1:0] eng_addr = '0;
    logic [DW-1:0] eng_wdata = '0;
    logic [DW-1:0] eng_rdata;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int lat;

    always #4 clk = ~clk;

    scratch_access_port #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_default(cfg_default),
        .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .data_we(data_we),
        .data_wdata(data_wdata), .cmd_rdata(cmd_rdata), .data_rdata(data_rdata),
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_rdata(eng_rdata)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [6:0] a);
        return {op, 4'h0, a, 1'b0};
    endfunction

    // Write data (if given) then command, at falling edges.
    task automatic issue(input logic [15:0] cmd, input logic wr, input logic [15:0] wd);
        if (wr) begin
            @(negedge clk);
            data_we = 1'b1; data_wdata = wd;
            @(negedge clk);
            data_we = 1'b0;
        end else begin
            @(negedge clk);
        end
        cmd_we = 1'b1; cmd_wdata = cmd;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    // Poll done; returns edges seen after the command edge (first poll = 1).
    task automatic wait_done(output int n);
        n = 1;
        while (!cmd_rdata[0] && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: got %0d expected below 150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cmd", {16'h0, cmd_rdata}, 32'h0);
        chk("R1 data", {16'h0, data_rdata}, 32'h0);
        chk("R1 eng", {16'h0, eng_rdata}, 32'h0);

        // Table walk over both controller states.
        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            logic [15:0] c;
            v = VEC[i];
            cfg_default = v[43];
            c = mk(v[42:39], v[38:32]);
            issue(c, v[42:39] == 4'h3, v[31:16]);
            wait_done(lat);
            if (v[42:39] == 4'h2) chk("R3 read data", {16'h0, data_rdata}, {16'h0, v[15:0]});
            else if (v[43]) chk("R5 write readback", {16'h0, data_rdata}, {16'h0, v[15:0]});
            else chk("R6 guarded write", {16'h0, data_rdata}, {16'h0, v[15:0]});
            chk("R2 cmd readback", {16'h0, cmd_rdata}, {16'h0, c[15:1], 1'b1});
        end

        // R4: idle-engine latency of write and read.
        cfg_default = 1'b1;
        issue(mk(4'h3, 7'h11), 1'b1, 16'h2468);
        wait_done(lat);
        chk("R4 write latency", lat, 4);
        chk("R4 readback", {16'h0, data_rdata}, 32'h2468);
        issue(mk(4'h2, 7'h11), 1'b0, 16'h0);
        wait_done(lat);
        chk("R4 read latency", lat, 3);

        // R9: malformed commands, done next edge, data unchanged.
        issue(16'h50E0, 1'b0, 16'h0);
        chk("R9 bad op done", {31'h0, cmd_rdata[0]}, 1);
        chk("R9 bad op data", {16'h0, data_rdata}, 32'h2468);
        issue(16'h2122, 1'b0, 16'h0);
        chk("R9 spare bits done", {31'h0, cmd_rdata[0]}, 1);
        chk("R9 spare bits data", {16'h0, data_rdata}, 32'h2468);

        // R11: engine write then engine read.
        @(negedge clk);
        eng_req = 1'b1; eng_we = 1'b1; eng_addr = 7'h10; eng_wdata = 16'h7777;
        @(negedge clk);
        eng_we = 1'b0;
        @(negedge clk);
        eng_req = 1'b0;
        chk("R11 engine read", {16'h0, eng_rdata}, 32'h7777);
        issue(mk(4'h2, 7'h10), 1'b0, 16'h0);
        wait_done(lat);
        chk("R11 host sees engine write", {16'h0, data_rdata}, 32'h7777);

        // R7/R8/R10: long engine hold with a pending host write.
        cfg_default = 1'b1;
        @(negedge clk);
        eng_req = 1'b1; eng_we = 1'b0; eng_addr = 7'h20;
        issue(mk(4'h3, 7'h30), 1'b1, 16'h4444);
        chk("R8 done cleared", {31'h0, cmd_rdata[0]}, 0);
        @(negedge clk);
        data_we = 1'b1; data_wdata = 16'h9999;
        cmd_we = 1'b1; cmd_wdata = mk(4'h2, 7'h70);
        @(negedge clk);
        data_we = 1'b0; cmd_we = 1'b0;
        chk("R8 pending cmd kept", {16'h0, cmd_rdata}, {16'h0, mk(4'h3, 7'h30)});
        repeat (1000) @(negedge clk);
        chk("R7 still pending", {31'h0, cmd_rdata[0]}, 0);
        eng_req = 1'b0;
        wait_done(lat);
        chk("R7 completes after release", {31'h0, cmd_rdata[0]}, 1);
        chk("R10 pending data kept", {16'h0, data_rdata}, 32'h4444);
        issue(mk(4'h2, 7'h30), 1'b0, 16'h0);
        wait_done(lat);
        chk("R10 stored value", {16'h0, data_rdata}, 32'h4444);

        // R6: restricted write to a non-reserved word leaves memory as is.
        cfg_default = 1'b0;
        issue(mk(4'h3, 7'h30), 1'b1, 16'h1111);
        wait_done(lat);
        chk("R6 zero returned", {16'h0, data_rdata}, 32'h0);
        issue(mk(4'h2, 7'h30), 1'b0, 16'h0);
        wait_done(lat);
        chk("R6 memory unchanged", {16'h0, data_rdata}, 32'h4444);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule